// File: doc/BRIEF.md
# Power-on reset sequencer

This block is the board-level reset controller that sits in front of an application processor and runs from the system reference clock. It merges three active-low reset requests into a single active-low power-on reset. The three requests are power-good, a debugger reset and a software or pushbutton reset. The block holds that reset low for a minimum time derived from the clock frequency and releases it with a single registered edge. A separate debug test-reset output follows power-good and a dedicated debugger test-reset request only.

While the processor is held in reset, the block presents a set of configuration strap values on a pad bus. The values are captured on the last clock on which a reset request was active, so they are already stable for the whole setup window before the rising edge. The block keeps driving them for a hold window after the edge and then turns the pad drivers off, because the processor reuses those pins as outputs. After the processor reset is released, the downstream resets for memory, PCIe, Ethernet PHY, USB hub and display are released one after another with a fixed gap between them. Any new request pulls everything back into reset at once.

Power-good low also acts as the asynchronous reset of the block itself. All request inputs pass through a synchronizer with a two-sample glitch filter.

Top module: `rst_por_sequencer`

## Requirements
- R1: While pwr_ok is low, por_n, trst_n and every periph_rst_n bit are 0, strap_oe is 1 and strap_out is all zeros.
- R2: Once the qualified request has ended, por_n rises exactly at the LOW-th following clock edge. LOW is the larger of CLK_HZ*MIN_ASSERT_US/1e6 and SETUP_CYC. For an input request held low for L clock samples, por_n is therefore low for L+LOW-2 clock cycles, and it is a registered output that changes in one step.
- R3: The power-on request is the OR of pwr_ok, dbg_rst_n and sw_rst_n being low (after qualification). A qualified request drives por_n low on the next clock edge and restarts the low period, including when it arrives while por_n is already low.
- R4: trst_n is low one edge after pwr_ok or dbg_trst_n is seen low (qualified) and high otherwise. sw_rst_n and dbg_rst_n have no effect on it, and dbg_trst_n has no effect on por_n.
- R5: strap_out holds the cfg_value sampled on the last clock edge at which the power-on request was active, and stays unchanged while por_n is high.
- R6: strap_oe is 1 from a request until exactly HOLD_CYC clock edges after the rising edge of por_n, then 0.
- R7: Every periph_rst_n bit is 0 while por_n is 0.
- R8: After por_n rises, periph_rst_n bits are released one per GAP_CYC clock edges in index order: bit 0 memory, bit 1 PCIe, bit 2 Ethernet PHY, bit 3 USB hub, bit 4 display. The first is released GAP_CYC edges after por_n is seen high.
- R9: A qualified power-on request clears all periph_rst_n bits, drives por_n low and turns strap_oe on, all on the next clock edge.
- R10: A request input counts only after two consecutive low clock samples; a low pulse of one sample has no effect. The outputs react on the third clock edge after the first low sample.
- R11: Back-to-back debugger reset requests each produce a complete por_n low period of the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| pwr_ok | input | 1 | Power-good, low = reset request; also asynchronous reset of the block |
| dbg_rst_n | input | 1 | Debugger reset request, active low |
| sw_rst_n | input | 1 | Software or pushbutton reset request, active low |
| dbg_trst_n | input | 1 | Debugger test-reset request, active low |
| cfg_value | input | CFG_W | Configuration strap values to present during reset |
| por_n | output | 1 | Processor power-on reset, active low |
| trst_n | output | 1 | Processor debug test reset, active low |
| strap_out | output | CFG_W | Data for the strap pad drivers |
| strap_oe | output | 1 | Enable for the strap pad drivers; 0 leaves the pads at high impedance |
| periph_rst_n | output | N_PERIPH | Downstream peripheral resets, active low, bit 0 released first |

## Verification
The bench goes after the restart cases. A second debugger request that lands mid-count must extend the low period rather than let por_n rise early. A request during peripheral staging must clear every released peripheral at once; a stager that only froze would leave memory or PCIe running while the processor is in reset. One-sample glitches on a request line must be filtered, and a missing filter shows up as a spurious short reset. The bench also checks the exact low length and the moment the strap drivers turn off. An off-by-one in either counter moves por_n or strap_oe by a cycle against the reference model, and a design that sampled the straps late or kept driving them would be caught by the same compare. The separation of the test reset from the software reset is checked in both directions.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_ASSERT = 2'd0,
    PH_HOLD   = 2'd1,
    PH_RUN    = 2'd2
  } por_phase_e;

  // positions of the request lines inside the filter bank
  localparam int unsigned REQ_PWR   = 0;
  localparam int unsigned REQ_DBG   = 1;
  localparam int unsigned REQ_SW    = 2;
  localparam int unsigned REQ_TRST  = 3;
  localparam int unsigned REQ_COUNT = 4;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input int unsigned us);
    longint unsigned prod;
    prod = clk_hz * longint'(us);
    return int'(prod / 64'd1000000);
  endfunction

  // processor reset low time: the time limit, but never shorter than the strap setup window
  function automatic int unsigned por_low_cycles(input longint unsigned clk_hz,
                                                 input int unsigned us,
                                                 input int unsigned setup);
    return max_u(max_u(us_to_cycles(clk_hz, us), setup), 1);
  endfunction

  function automatic int unsigned ctr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rst_req_filter.sv
module rst_req_filter #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [N_REQ-1:0] req_n_i,
  output logic [N_REQ-1:0] req_q_o
);

  genvar g;
  generate
    for (g = 0; g < N_REQ; g++) begin : g_chan
      // [0],[1] synchronizer, [2] previous synchronized sample
      logic [2:0] samp;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) samp <= '0;
        else         samp <= {samp[1:0], req_n_i[g]};
      end

      assign req_q_o[g] = ~samp[1] & ~samp[2];

      // R10
      two_sample_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(req_q_o[g]) |-> ($past(!req_n_i[g], 2) && $past(!req_n_i[g], 3)));
    end
  endgenerate

endmodule

// File: rtl/rst_por_timer.sv
module rst_por_timer
  import rst_seq_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 50000,
  parameter int unsigned HOLD_CYC = 16,
  parameter int unsigned CFG_W    = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             req_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             por_n_o,
  output logic [CFG_W-1:0] strap_o,
  output logic             strap_oe_o
);

  localparam int unsigned CW   = ctr_bits(max_u(LOW_CYC, HOLD_CYC));
  localparam int unsigned LW   = ctr_bits(LOW_CYC + 1) + 1;
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  por_phase_e    phase;
  logic [CW-1:0] cnt;

  // named events for the checks
  logic rise_evt;
  logic hold_done_evt;
  assign rise_evt      = (phase == PH_ASSERT) && !req_i && (cnt == LOW_LAST);
  assign hold_done_evt = (phase == PH_HOLD)   && !req_i && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase      <= PH_ASSERT;
      cnt        <= '0;
      por_n_o    <= 1'b0;
      strap_oe_o <= 1'b1;
      strap_o    <= '0;
    end else if (req_i) begin
      phase      <= PH_ASSERT;
      cnt        <= '0;
      por_n_o    <= 1'b0;
      strap_oe_o <= 1'b1;
      strap_o    <= cfg_i;
    end else begin
      unique case (phase)
        PH_ASSERT: begin
          if (rise_evt) begin
            por_n_o <= 1'b1;
            phase   <= PH_HOLD;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (hold_done_evt) begin
            strap_oe_o <= 1'b0;
            phase      <= PH_RUN;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // checker: cycles por_n has been low, saturating
  logic [LW-1:0] low_len;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                      low_len <= '0;
    else if (por_n_o)                 low_len <= '0;
    else if (low_len < LW'(LOW_CYC))  low_len <= low_len + 1'b1;
  end

  // R2
  min_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(por_n_o) |-> (low_len >= LW'(LOW_CYC)));

  // R3
  req_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    req_i |=> (!por_n_o && strap_oe_o));

  // R5
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!arst_n)
    por_n_o |-> $stable(strap_o));

  // R6
  strap_late_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(strap_oe_o) |-> (por_n_o && $past(por_n_o)));

  // R6
  strap_at_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(por_n_o) |-> strap_oe_o);

endmodule

// File: rtl/rst_periph_stager.sv
module rst_periph_stager
  import rst_seq_pkg::*;
#(
  parameter int unsigned N_PERIPH = 5,
  parameter int unsigned GAP_CYC  = 1024
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                clear_i,
  input  logic                go_i,
  output logic [N_PERIPH-1:0] rel_n_o
);

  localparam int unsigned GW = ctr_bits(GAP_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  logic [GW-1:0] gap_cnt;
  logic          all_out;
  logic          step_evt;

  assign all_out  = rel_n_o[N_PERIPH-1];
  assign step_evt = go_i && !all_out && (gap_cnt == GAP_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rel_n_o <= '0;
      gap_cnt <= '0;
    end else if (clear_i) begin
      rel_n_o <= '0;
      gap_cnt <= '0;
    end else if (go_i && !all_out) begin
      if (step_evt) begin
        rel_n_o <= (rel_n_o << 1) | N_PERIPH'(1);
        gap_cnt <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R7
  held_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !go_i |-> (rel_n_o == '0));

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!arst_n)
    clear_i |=> (rel_n_o == '0));

  // R8
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !clear_i |=> ($countones(rel_n_o & ~$past(rel_n_o)) <= 1));

  genvar g;
  generate
    for (g = 1; g < N_PERIPH; g++) begin : g_order
      // R8
      in_order_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rel_n_o[g] |-> rel_n_o[g-1]);
    end
  endgenerate

endmodule

// File: rtl/rst_por_sequencer.sv
module rst_por_sequencer
  import rst_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ        = 50000000,
  parameter int unsigned     MIN_ASSERT_US = 1000,
  parameter int unsigned     SETUP_CYC     = 16,
  parameter int unsigned     HOLD_CYC      = 16,
  parameter int unsigned     GAP_CYC       = 1024,
  parameter int unsigned     CFG_W         = 4,
  parameter int unsigned     N_PERIPH      = 5
) (
  input  logic                clk,
  input  logic                pwr_ok,
  input  logic                dbg_rst_n,
  input  logic                sw_rst_n,
  input  logic                dbg_trst_n,
  input  logic [CFG_W-1:0]    cfg_value,
  output logic                por_n,
  output logic                trst_n,
  output logic [CFG_W-1:0]    strap_out,
  output logic                strap_oe,
  output logic [N_PERIPH-1:0] periph_rst_n
);

  localparam int unsigned LOW_CYC = por_low_cycles(CLK_HZ, MIN_ASSERT_US, SETUP_CYC);

  logic [REQ_COUNT-1:0] raw_n;
  logic [REQ_COUNT-1:0] req_q;
  logic                 por_req;
  logic                 trst_req;

  assign raw_n[REQ_PWR]  = pwr_ok;
  assign raw_n[REQ_DBG]  = dbg_rst_n;
  assign raw_n[REQ_SW]   = sw_rst_n;
  assign raw_n[REQ_TRST] = dbg_trst_n;

  rst_req_filter #(.N_REQ(REQ_COUNT)) u_filter (
    .clk     (clk),
    .arst_n  (pwr_ok),
    .req_n_i (raw_n),
    .req_q_o (req_q)
  );

  assign por_req  = req_q[REQ_PWR] | req_q[REQ_DBG] | req_q[REQ_SW];
  assign trst_req = req_q[REQ_PWR] | req_q[REQ_TRST];

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) trst_n <= 1'b0;
    else         trst_n <= ~trst_req;
  end

  rst_por_timer #(
    .LOW_CYC  (LOW_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CFG_W    (CFG_W)
  ) u_timer (
    .clk        (clk),
    .arst_n     (pwr_ok),
    .req_i      (por_req),
    .cfg_i      (cfg_value),
    .por_n_o    (por_n),
    .strap_o    (strap_out),
    .strap_oe_o (strap_oe)
  );

  rst_periph_stager #(
    .N_PERIPH (N_PERIPH),
    .GAP_CYC  (GAP_CYC)
  ) u_stager (
    .clk     (clk),
    .arst_n  (pwr_ok),
    .clear_i (por_req),
    .go_i    (por_n),
    .rel_n_o (periph_rst_n)
  );

  // R4
  trst_follow_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    trst_req |=> !trst_n);

  // R4
  trst_release_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
    !trst_req |=> trst_n);

endmodule

// File: tb/rst_por_sequencer_bench.sv
module rst_por_sequencer_bench;

  localparam longint unsigned CLK_HZ = 50000000;
  localparam int MIN_US = 20;
  localparam int SETUP  = 16;
  localparam int HOLD   = 16;
  localparam int GAP    = 64;
  localparam int W      = 4;
  localparam int NP     = 5;
  localparam int TIME_CYC = int'((CLK_HZ / 1000000) * MIN_US);
  localparam int LOW    = (TIME_CYC > SETUP) ? TIME_CYC : SETUP;
  localparam int FULL   = LOW + HOLD + NP * GAP + 40;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0;
  logic dbg_rst_n = 1'b1;
  logic sw_rst_n = 1'b1;
  logic dbg_trst_n = 1'b1;
  logic [W-1:0] cfg_value = 4'h3;
  logic por_n, trst_n, strap_oe;
  logic [W-1:0] strap_out;
  logic [NP-1:0] periph_rst_n;

  rst_por_sequencer #(
    .CLK_HZ(CLK_HZ), .MIN_ASSERT_US(MIN_US), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
    .GAP_CYC(GAP), .CFG_W(W), .N_PERIPH(NP)
  ) u_rst_por_sequencer (
    .clk(clk), .pwr_ok(pwr_ok), .dbg_rst_n(dbg_rst_n), .sw_rst_n(sw_rst_n),
    .dbg_trst_n(dbg_trst_n), .cfg_value(cfg_value), .por_n(por_n), .trst_n(trst_n),
    .strap_out(strap_out), .strap_oe(strap_oe), .periph_rst_n(periph_rst_n)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // per input: [0]=sample one edge ago, [1]=two ago, [2]=three ago
  bit [2:0] hist [4];
  bit m_por, m_trst, m_oe;
  bit [W-1:0] m_strap;
  int m_phase, m_cnt, m_rel, m_gap;

  function automatic bit seen_low(input int i);
    return !hist[i][1] && !hist[i][2];
  endfunction

  always @(posedge clk) begin
    bit rq, tq, por_old;
    bit [3:0] now;
    now = {dbg_trst_n, sw_rst_n, dbg_rst_n, pwr_ok};
    if (!pwr_ok) begin
      for (int i = 0; i < 4; i++) hist[i] = '0;
      m_por = 0; m_trst = 0; m_oe = 1; m_strap = '0;
      m_phase = 0; m_cnt = 0; m_rel = 0; m_gap = 0;
    end else begin
      rq = seen_low(0) || seen_low(1) || seen_low(2);
      tq = seen_low(0) || seen_low(3);
      por_old = m_por;
      if (rq) begin
        m_phase = 0; m_cnt = 0; m_por = 0; m_oe = 1; m_strap = cfg_value;
        m_rel = 0; m_gap = 0;
      end else begin
        if (m_phase == 0) begin
          if (m_cnt == LOW - 1) begin m_por = 1; m_phase = 1; m_cnt = 0; end
          else m_cnt++;
        end else if (m_phase == 1) begin
          if (m_cnt == HOLD - 1) begin m_oe = 0; m_phase = 2; m_cnt = 0; end
          else m_cnt++;
        end
        if (por_old && m_rel < NP) begin
          if (m_gap == GAP - 1) begin m_rel++; m_gap = 0; end
          else m_gap++;
        end
      end
      m_trst = !tq;
      for (int i = 0; i < 4; i++) hist[i] = {hist[i][1:0], now[i]};
    end
  end

  // ---------------- per-clock compare and measurement ----------------
  int low_run = 0;
  int last_run = 0;
  int rises = 0;
  bit trst_seen_low = 0;

  always @(posedge clk) begin
    logic [NP-1:0] exp_rel;
    #5;
    exp_rel = NP'((1 << m_rel) - 1);
    check(por_n === m_por, "R3 por_n vs model", por_n, m_por);
    check(trst_n === m_trst, "R4 trst_n vs model", trst_n, m_trst);
    check(strap_oe === m_oe, "R6 strap_oe vs model", strap_oe, m_oe);
    check(strap_out === m_strap, "R5 strap_out vs model", strap_out, m_strap);
    check(periph_rst_n === exp_rel, "R8 periph_rst_n vs model", periph_rst_n, exp_rel);
    if (!trst_n) trst_seen_low = 1;
    if (por_n === 1'b0) low_run++;
    else if (low_run > 0) begin last_run = low_run; rises++; low_run = 0; end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 1 debugger reset, 2 software reset, 3 debugger test reset
  task automatic pulse(input int which, input int len);
    @(negedge clk);
    case (which)
      1: dbg_rst_n = 0;
      2: sw_rst_n = 0;
      default: dbg_trst_n = 0;
    endcase
    repeat (len) @(negedge clk);
    dbg_rst_n = 1; sw_rst_n = 1; dbg_trst_n = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int r0;
    // R1 reset state while power is not good
    wait_cyc(4);
    check(por_n === 1'b0, "R1 por_n in power-down", por_n, 0);
    check(trst_n === 1'b0, "R1 trst_n in power-down", trst_n, 0);
    check(periph_rst_n === '0, "R1 periph in power-down", periph_rst_n, 0);
    check(strap_oe === 1'b1, "R1 strap_oe in power-down", strap_oe, 1);
    check(strap_out === '0, "R1 strap_out in power-down", strap_out, 0);

    pwr_ok = 1;
    wait_cyc(FULL);
    check(last_run >= LOW, "R2 power-up low length", last_run, LOW);
    check(por_n === 1'b1, "R2 por_n released", por_n, 1);
    check(strap_oe === 1'b0, "R6 straps released", strap_oe, 0);
    check(periph_rst_n === {NP{1'b1}}, "R8 all peripherals out", periph_rst_n, {NP{1'b1}});
    check(strap_out === 4'h3, "R5 strap value captured", strap_out, 3);

    // software reset of 5 samples, cfg changes afterwards
    cfg_value = 4'hA;
    trst_seen_low = 0;
    pulse(2, 5);
    wait_cyc(6);
    cfg_value = 4'h5;
    wait_cyc(FULL);
    check(last_run == 5 + LOW - 2, "R2 exact low length", last_run, 5 + LOW - 2);
    check(strap_out === 4'hA, "R5 late cfg change ignored", strap_out, 4'hA);
    check(!trst_seen_low, "R4 sw reset leaves trst_n", trst_seen_low, 0);

    // single-sample glitch
    r0 = rises;
    pulse(2, 1);
    wait_cyc(20);
    check(por_n === 1'b1, "R10 glitch filtered", por_n, 1);
    check(rises == r0 && low_run == 0, "R10 no extra reset", rises, r0);

    // repeated debugger requests
    for (int k = 0; k < 3; k++) begin
      pulse(1, 4);
      wait_cyc(FULL);
      check(last_run == 4 + LOW - 2, "R11 repeated request full period", last_run, 4 + LOW - 2);
    end

    // restart while still low
    pulse(1, 4);
    wait_cyc(500);
    pulse(1, 4);
    wait_cyc(FULL);
    check(last_run >= LOW + 500, "R3 restart extends low period", last_run, LOW + 500);

    // test-reset request alone
    r0 = rises;
    trst_seen_low = 0;
    pulse(3, 4);
    wait_cyc(10);
    check(trst_seen_low, "R4 trst request seen", trst_seen_low, 1);
    check(por_n === 1'b1 && rises == r0 && low_run == 0, "R4 trst leaves por_n", por_n, 1);

    // request during peripheral staging
    pulse(2, 3);
    wait_cyc(LOW + HOLD + 2 * GAP + 10);
    check(periph_rst_n[0] === 1'b1 && periph_rst_n[NP-1] === 1'b0, "R8 partial staging",
          periph_rst_n, 3);
    pulse(1, 3);
    wait_cyc(5);
    check(periph_rst_n === '0, "R9 peripherals re-asserted", periph_rst_n, 0);
    check(por_n === 1'b0, "R7 por_n low with peripherals", por_n, 0);
    check(strap_oe === 1'b1, "R9 straps driven again", strap_oe, 1);
    wait_cyc(FULL);
    check(periph_rst_n === {NP{1'b1}}, "R8 staging completes", periph_rst_n, {NP{1'b1}});

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule